// File: doc/BRIEF.md
# Two-Partition Spare Switching Controller

This block keeps track of which hardware units belong to the working (primary) partition and which belong to the standby partition. The units come in five types: processors, program memories, data memories, timing/status units and I/O controllers. Each type holds one unit more than the primary side needs, and that extra unit sits in standby as a hot spare. Every cycle the block reads a health bit for each unit. When a primary unit goes unhealthy, the block moves it out of primary and brings in a healthy spare of the same type on the same edge. One cycle later it isolates the failed unit inside standby and pulses a diagnostic request that names the unit.

Software can load any split with a configuration write. Both partition controllers may also ask to move single units. The primary controller always wins. The standby controller cannot pull a unit out of primary at all. A programmable cycle budget bounds how long primary may hold a failed unit, and a sticky flag reports when the budget is overrun. A one-cycle pulse tells the primary side each time its membership changes.

Unit indices run in ascending blocks by type: processors first, then program memories, data memories, timing/status units and I/O controllers. With the default parameters the blocks are 0-10, 11-27, 28-44, 45-46 and 47-48.

Top module: `spare_switch_ctrl`

## Requirements
- R1: After reset, the highest-index unit of each type is in standby and every other unit is in primary. Ownership bit 1 means primary. No unit is isolated, and `recov_pulse`, `diag_vld`, `degraded` and `timeout` are all low.
- R2: When `cfg_we` is high, `own_pri` equals `cfg_own` after the next edge. The same edge clears the isolation mask, `degraded`, `timeout` and any failover step in flight. A configuration write overrides every other action in that cycle.
- R3: When a primary unit has `unit_ok` low, the next edge clears its ownership bit. On that same edge, the lowest-index standby unit of the same type that is healthy and not isolated joins primary.
- R4: One edge after a unit is switched out by failover, its `iso` bit is set. In that same cycle `diag_vld` is high for exactly one cycle, with `diag_unit` equal to the unit's index.
- R5: If no usable spare of the failed unit's type exists, the failed unit still leaves primary and nothing joins. `degraded` goes high and stays high until a configuration write.
- R6: When several primary units fail together, they are switched out one per edge, lowest index first.
- R7: A counter counts consecutive cycles in which primary holds a failed unit. If such a cycle begins with the count at or above `budget`, `timeout` is set and stays set until a configuration write.
- R8: Each request carries a unit index and a destination (1 = primary, 0 = standby). When both controllers request in the same cycle, the primary request is served and the standby request is dropped. A standby request for a unit that is currently primary is refused. Any request is refused if its index is out of range or names an isolated unit. A request to move an unhealthy unit into primary is also refused.
- R9: `recov_pulse` is high for one cycle, in exactly the cycles where `own_pri` differs from its value in the previous cycle.
- R10: Requests are dropped, not queued, in any cycle where primary holds a failed unit or an isolation step is pending.
- R11: A unit is never in primary and isolated at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the split from `cfg_own` |
| cfg_own | input | 49 | Split to load, 1 = primary |
| unit_ok | input | 49 | Per-unit health, 1 = healthy |
| budget | input | 16 | Allowed cycles with a failed unit in primary |
| pri_req_vld | input | 1 | Primary-side move request |
| pri_req_unit | input | 6 | Unit index of the primary request |
| pri_req_dst | input | 1 | Destination of the primary request, 1 = primary |
| stby_req_vld | input | 1 | Standby-side move request |
| stby_req_unit | input | 6 | Unit index of the standby request |
| stby_req_dst | input | 1 | Destination of the standby request, 1 = primary |
| own_pri | output | 49 | Ownership bitmap, 1 = primary |
| iso | output | 49 | Isolation mask within standby |
| diag_vld | output | 1 | Diagnostic request pulse |
| diag_unit | output | 6 | Unit named by the diagnostic request |
| recov_pulse | output | 1 | Primary membership changed |
| degraded | output | 1 | A failover found no spare |
| timeout | output | 1 | The failover budget was overrun |

## Verification
Two pairs of functions can act in the same cycle. The first is a failover and a move request. The bench drops a primary unit's health in the same cycle that a valid primary request is presented. It then checks that the failover alone changes ownership and that the requested unit keeps its partition. The second pair is the two controllers requesting together. The bench presents a primary request and a standby request in one cycle and checks that only the primary request takes effect. Simultaneous failures inside one type, with only one spare, are used to judge the order of service, the degraded flag and the budget boundary all at once.

// File: rtl/spare_switch_ctrl.sv
module spare_switch_ctrl #(
  parameter int NPROC = 11,
  parameter int NPMEM = 17,
  parameter int NDMEM = 17,
  parameter int NTIME = 2,
  parameter int NIOC  = 2,
  parameter int CW    = 16,
  localparam int B1 = NPROC,
  localparam int B2 = B1 + NPMEM,
  localparam int B3 = B2 + NDMEM,
  localparam int B4 = B3 + NTIME,
  localparam int N  = B4 + NIOC,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [N-1:0]  cfg_own,
  input  logic [N-1:0]  unit_ok,
  input  logic [CW-1:0] budget,
  input  logic          pri_req_vld,
  input  logic [IW-1:0] pri_req_unit,
  input  logic          pri_req_dst,
  input  logic          stby_req_vld,
  input  logic [IW-1:0] stby_req_unit,
  input  logic          stby_req_dst,
  output logic [N-1:0]  own_pri,
  output logic [N-1:0]  iso,
  output logic          diag_vld,
  output logic [IW-1:0] diag_unit,
  output logic          recov_pulse,
  output logic          degraded,
  output logic          timeout
);

  function automatic int utype(input int i);
    if (i < B1) return 0;
    if (i < B2) return 1;
    if (i < B3) return 2;
    if (i < B4) return 3;
    return 4;
  endfunction

  function automatic logic [N-1:0] home_split();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++)
      m[i] = !((i + 1 == N) || (utype(i + 1) != utype(i)));
    return m;
  endfunction

  logic [N-1:0]  own_q, own_nx, iso_q, bad;
  logic [IW-1:0] f_idx, s_idx, sw_idx;
  logic          f_vld, s_vld, sw_vld, pend, idle, pri_ok, stby_ok;
  logic [CW-1:0] cnt;

  assign bad  = own_q & ~unit_ok;
  assign pend = |bad;
  assign idle = !pend && !sw_vld;

  always_comb begin
    f_vld = 1'b0;
    f_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (bad[i]) begin
        f_vld = 1'b1;
        f_idx = IW'(i);
      end
  end

  always_comb begin
    s_vld = 1'b0;
    s_idx = '0;
    for (int j = N - 1; j >= 0; j--)
      if (!own_q[j] && unit_ok[j] && !iso_q[j] && utype(j) == utype(int'(f_idx))
          && !(sw_vld && int'(sw_idx) == j)) begin
        s_vld = 1'b1;
        s_idx = IW'(j);
      end
  end

  assign pri_ok = pri_req_vld && int'(pri_req_unit) < N && !iso_q[pri_req_unit]
                  && !(pri_req_dst && !unit_ok[pri_req_unit]);
  assign stby_ok = stby_req_vld && int'(stby_req_unit) < N && !iso_q[stby_req_unit]
                   && !own_q[stby_req_unit] && !(stby_req_dst && !unit_ok[stby_req_unit]);

  always_comb begin
    own_nx = own_q;
    if (cfg_we)
      own_nx = cfg_own;
    else if (f_vld) begin
      own_nx[f_idx] = 1'b0;
      if (s_vld) own_nx[s_idx] = 1'b1;
    end else if (idle) begin
      if (pri_ok)       own_nx[pri_req_unit]  = pri_req_dst;
      else if (stby_ok) own_nx[stby_req_unit] = stby_req_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q       <= home_split();
      iso_q       <= '0;
      sw_vld      <= 1'b0;
      sw_idx      <= '0;
      diag_vld    <= 1'b0;
      diag_unit   <= '0;
      recov_pulse <= 1'b0;
      degraded    <= 1'b0;
      timeout     <= 1'b0;
      cnt         <= '0;
    end else begin
      own_q       <= own_nx;
      recov_pulse <= (own_nx != own_q);
      sw_vld      <= !cfg_we && f_vld;
      sw_idx      <= f_idx;
      diag_vld    <= !cfg_we && sw_vld;
      diag_unit   <= sw_idx;
      if (cfg_we) begin
        iso_q    <= '0;
        degraded <= 1'b0;
        timeout  <= 1'b0;
        cnt      <= '0;
      end else begin
        if (sw_vld) iso_q[sw_idx] <= 1'b1;
        if (f_vld && !s_vld) degraded <= 1'b1;
        if (pend) begin
          if (cnt >= budget) timeout <= 1'b1;
          if (cnt != '1) cnt <= cnt + 1'b1;
        end else
          cnt <= '0;
      end
    end
  end

  assign own_pri = own_q;
  assign iso     = iso_q;

  // R11
  iso_not_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q & iso_q) == '0);

  // R4
  diag_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_vld |-> (iso_q[diag_unit] && !own_q[diag_unit]));

  // R3
  swap_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $countones(own_q ^ $past(own_q)) <= 2);

  // R8
  stby_no_steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_req_vld && !pri_req_vld && !cfg_we && int'(stby_req_unit) < N
     && own_q[stby_req_unit] && unit_ok[stby_req_unit]) |=> own_q[$past(stby_req_unit)]);

  // R5
  degraded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (degraded && !cfg_we) |=> degraded);

  // R9
  recov_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_pulse |-> (own_q != $past(own_q)));

endmodule

// File: tb/spare_switch_ctrl_tb.sv
module spare_switch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 49;
  localparam int IW = 6;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [N-1:0] cfg_own = '0, unit_ok = '1;
  logic [15:0] budget = 16'd100;
  logic pri_req_vld = 0, pri_req_dst = 0, stby_req_vld = 0, stby_req_dst = 0;
  logic [IW-1:0] pri_req_unit = '0, stby_req_unit = '0;
  logic [N-1:0] own_pri, iso;
  logic diag_vld, recov_pulse, degraded, timeout;
  logic [IW-1:0] diag_unit;

  int checks = 0, fails = 0;
  logic [N-1:0] home, exp_own;

  spare_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_own(cfg_own), .unit_ok(unit_ok),
    .budget(budget), .pri_req_vld(pri_req_vld), .pri_req_unit(pri_req_unit),
    .pri_req_dst(pri_req_dst), .stby_req_vld(stby_req_vld), .stby_req_unit(stby_req_unit),
    .stby_req_dst(stby_req_dst), .own_pri(own_pri), .iso(iso), .diag_vld(diag_vld),
    .diag_unit(diag_unit), .recov_pulse(recov_pulse), .degraded(degraded), .timeout(timeout));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [N-1:0] b(input int i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic baseline();
    unit_ok = '1;
    budget = 16'd100;
    cfg_own = home;
    cfg_we = 1;
    tick();
    cfg_we = 0;
    exp_own = home;
    eq("R2 split reload", 64'(own_pri), 64'(home));
    eq("R2 iso cleared", 64'(iso), 0);
    eq("R2 flags cleared", {62'd0, degraded, timeout}, 0);
  endtask

  task automatic t_reset();
    eq("R1 reset split", 64'(own_pri), 64'(home));
    eq("R1 reset iso", 64'(iso), 0);
    eq("R1 reset flags", {60'd0, recov_pulse, diag_vld, degraded, timeout}, 0);
  endtask

  task automatic t_single();
    unit_ok[3] = 0;
    tick();
    eq("R3 proc 3 swapped with spare 10", 64'(own_pri), 64'((home & ~b(3)) | b(10)));
    eq("R9 recov pulse on change", 64'(recov_pulse), 1);
    eq("R4 no diag on swap edge", 64'(diag_vld), 0);
    tick();
    eq("R4 iso set", 64'(iso), 64'(b(3)));
    eq("R4 diag pulse", {57'd0, diag_vld, diag_unit}, {57'd0, 1'b1, 6'd3});
    eq("R9 recov one cycle", 64'(recov_pulse), 0);
    tick();
    eq("R4 diag one cycle", 64'(diag_vld), 0);
    eq("R5 spare found no degrade", 64'(degraded), 0);
    baseline();
  endtask

  task automatic t_cfg();
    logic [N-1:0] pat;
    pat = 49'h1_5A3C_0F0F_9124;
    cfg_own = pat;
    cfg_we = 1;
    tick();
    cfg_we = 0;
    eq("R2 arbitrary split", 64'(own_pri), 64'(pat));
    eq("R9 recov on cfg", 64'(recov_pulse), 1);
    baseline();
  endtask

  task automatic t_degrade();
    cfg_own = home | b(10);
    cfg_we = 1;
    tick();
    cfg_we = 0;
    unit_ok[5] = 0;
    tick();
    eq("R5 removed without spare", 64'(own_pri), 64'((home | b(10)) & ~b(5)));
    eq("R5 degraded set", 64'(degraded), 1);
    tick();
    eq("R5 iso on degraded unit", 64'(iso), 64'(b(5)));
    tick();
    eq("R5 degraded sticky", 64'(degraded), 1);
    baseline();
  endtask

  task automatic t_multi();
    unit_ok[30] = 0;
    unit_ok[12] = 0;
    unit_ok[0] = 0;
    tick();
    exp_own = (home & ~b(0)) | b(10);
    eq("R6 lowest index first", 64'(own_pri), 64'(exp_own));
    tick();
    exp_own = (exp_own & ~b(12)) | b(27);
    eq("R6 second failure", 64'(own_pri), 64'(exp_own));
    eq("R4 diag first unit", 64'(diag_unit), 0);
    tick();
    exp_own = (exp_own & ~b(30)) | b(44);
    eq("R6 third failure", 64'(own_pri), 64'(exp_own));
    eq("R4 diag second unit", 64'(diag_unit), 12);
    tick();
    eq("R4 diag third unit", {57'd0, diag_vld, diag_unit}, {57'd0, 1'b1, 6'd30});
    eq("R4 iso all three", 64'(iso), 64'(b(0) | b(12) | b(30)));
    eq("R7 no timeout within budget", 64'(timeout), 0);
    baseline();
  endtask

  task automatic t_timeout();
    budget = 16'd2;
    unit_ok[1] = 0;
    unit_ok[2] = 0;
    tick(); tick(); tick();
    eq("R7 two pending cycles budget 2", 64'(timeout), 0);
    eq("R5 second failure without spare", 64'(degraded), 1);
    baseline();
    budget = 16'd1;
    unit_ok[11] = 0;
    unit_ok[12] = 0;
    tick();
    eq("R7 not yet over budget", 64'(timeout), 0);
    tick();
    eq("R7 timeout set", 64'(timeout), 1);
    tick();
    eq("R7 timeout sticky", 64'(timeout), 1);
    baseline();
  endtask

  task automatic t_req();
    pri_req_vld = 1; pri_req_unit = 4; pri_req_dst = 0;
    tick();
    pri_req_vld = 0;
    exp_own = home & ~b(4);
    eq("R8 primary request moves unit", 64'(own_pri), 64'(exp_own));
    stby_req_vld = 1; stby_req_unit = 5; stby_req_dst = 0;
    tick();
    eq("R8 standby cannot take primary unit", 64'(own_pri), 64'(exp_own));
    stby_req_unit = 4; stby_req_dst = 1;
    tick();
    exp_own = home;
    eq("R8 standby promotes its own unit", 64'(own_pri), 64'(exp_own));
    pri_req_vld = 1; pri_req_unit = 6; pri_req_dst = 0;
    stby_req_unit = 10; stby_req_dst = 1;
    tick();
    pri_req_vld = 0; stby_req_vld = 0;
    exp_own = home & ~b(6);
    eq("R8 primary request wins", 64'(own_pri), 64'(exp_own));
    pri_req_vld = 1; pri_req_unit = 6; pri_req_dst = 1;
    unit_ok[6] = 0;
    tick();
    eq("R8 unhealthy unit not promoted", 64'(own_pri), 64'(exp_own));
    pri_req_vld = 0;
    baseline();
    unit_ok[7] = 0;
    pri_req_vld = 1; pri_req_unit = 20; pri_req_dst = 0;
    tick();
    exp_own = (home & ~b(7)) | b(10);
    eq("R10 request dropped during failover", 64'(own_pri), 64'(exp_own));
    tick();
    eq("R10 request dropped during isolation step", 64'(own_pri), 64'(exp_own));
    pri_req_unit = 7; pri_req_dst = 1;
    unit_ok[7] = 1;
    tick();
    eq("R8 isolated unit not promoted", 64'(own_pri), 64'(exp_own));
    pri_req_unit = 6'd60; pri_req_dst = 0;
    tick();
    eq("R8 out of range refused", 64'(own_pri), 64'(exp_own));
    pri_req_vld = 0;
    baseline();
  endtask

  initial begin
    home = '1;
    home[10] = 0; home[27] = 0; home[44] = 0; home[46] = 0; home[48] = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_single();
    t_cfg();
    t_degrade();
    t_multi();
    t_timeout();
    t_req();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule